// File: doc/BRIEF.md
# SPI Slave Controller with Receive Overflow and Transmit Collision Detection

This block is the slave end of a four-wire serial link. An external master drives the serial clock, the select line and the input data line. The block shifts received bits into a small receive queue and shifts transmit bits out of a shift register that is fed from a one-word holding register. Words are 8, 16 or 32 bits long and are sent most significant bit first. The clock polarity and the clock phase are both selectable. The master must use the same word size.

The serial clock, the select line and the input data line are each passed through a two-flop synchronizer into the system clock domain, and edges are detected there. The system clock must therefore run at least four times faster than the serial clock.

Two sticky error flags are provided. The overflow flag is raised when a word finishes arriving while the receive queue is full. The collision flag is raised when software writes transmit data too late, at or just after the moment the shift register is loaded for the next word, so that the first bit of that word could not meet setup. When the collision flag is raised, the word goes out with the old shift-register contents, and the new data is kept for the following word.

The control state machine has three states.
- `S_OFF` means disabled.
- `S_IDLE` means enabled but deselected.
- `S_ACTIVE` means selected and shifting.

It has four transitions.
- `T_ENABLE` goes from `S_OFF` to `S_IDLE` when the enable bit is set.
- `T_SELECT` goes from `S_IDLE` to `S_ACTIVE` when the synchronized select line is low.
- `T_DESELECT` goes from `S_ACTIVE` to `S_IDLE` when the select line rises. Any partial word is dropped.
- `T_DISABLE` goes from any state to `S_OFF` when the enable bit is cleared.

Configuration may be changed only while the block is disabled or deselected.

Top module: `spi_slave_err`

## Requirements
- R1: `cfg_wsize` selects the word length: 2'b00 gives 8 bits, 2'b01 gives 16 bits, and 2'b10 or 2'b11 gives 32 bits. Both directions shift most significant bit first. A received word appears right-justified on `rx_rdata`, with the unused upper bits zero. Only the low word-length bits of transmit data are sent.
- R2: `cfg_cpol` gives the idle level of `sclk`. The leading edge is the edge that leaves the idle level. With `cfg_cpha`=0 the block samples `mosi` on leading edges and advances `miso` on trailing edges. With `cfg_cpha`=1 it advances `miso` on leading edges and samples `mosi` on trailing edges.
- R3: Completed words enter a receive queue of RX_DEPTH entries (4 by default). `rx_rdata` shows the oldest word while `rx_empty` is 0, and a one-cycle `rx_rd` pulse removes that word. After reset, `rx_empty`=1, `tx_full`=0, both error flags are 0 and `miso`=0.
- R4: If a word completes while the queue holds RX_DEPTH words and no `rx_rd` pulse falls in the same cycle, that word is discarded. The stored words are unchanged, and `err_ovf` is set.
- R5: The shift register is loaded at a defined point for each phase mode.
  - With `cfg_cpha`=1, it loads on the first leading edge of each word.
  - With `cfg_cpha`=0, it loads when the block is enabled and when the select line is deasserted.
  - With `cfg_cpha`=0 and `cfg_ss_stall`=1, it also loads on the final `sclk` edge of every word.
  - A load takes the holding register if `tx_full`=1, and otherwise takes zero. A load clears `tx_full`. A `tx_wr` pulse sets `tx_full`.
- R6: A `tx_wr` pulse sets `err_txc` if it falls in the cycle of a load or within the GUARD cycles after it (GUARD is 4 by default). The word being sent then keeps the contents the shift register was loaded with. The written data stays in the holding register and is used by the next load.
- R7: Both error flags are sticky. A one-cycle pulse on `err_clr[0]` clears `err_ovf`, and a pulse on `err_clr[1]` clears `err_txc`. If an error occurs in the same cycle as the clear of its own flag, the flag ends up set.
- R8: While `cfg_en`=0, the block is in `S_OFF` and ignores `sclk` and `mosi`, even if `ss_n` is held low. No word enters the queue. If the select line rises in the middle of a word, the partial bits are dropped, and the next word starts at bit zero.
- R9: `miso` is 0 unless the block is enabled and selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable; 0 holds the block in S_OFF |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_ss_stall | input | 1 | With phase 0, reload the shift register at each word's final edge |
| cfg_wsize | input | 2 | Word length select (8/16/32) |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 32 | Transmit data |
| tx_full | output | 1 | Holding register holds unsent data |
| rx_rd | input | 1 | Pop strobe for the receive queue |
| rx_rdata | output | 32 | Oldest received word |
| rx_empty | output | 1 | Receive queue is empty |
| err_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 collision |
| err_ovf | output | 1 | Sticky receive overflow flag |
| err_txc | output | 1 | Sticky transmit collision flag |

## Verification
The two functions that can coincide are raising an error flag and clearing that same flag. The bench fills the receive queue with four words and then sends a fifth. It places the `err_clr[0]` pulse in the exact cycle where the synchronized final edge of the fifth word is registered. The result is judged correct when `err_ovf` reads 1 afterwards and the queue still returns the first four words in order. In the same spirit, a transmit write is placed inside the guard window just after a shift-register load, in both phase modes. The bench then checks both that the current word goes out with the old contents and that the late data is sent one word later.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int SPIS_DW = 32;

    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_IDLE   = 2'd1,
        S_ACTIVE = 2'd2
    } spis_state_t;

    // Word length in bits for a size code.
    function automatic logic [5:0] spis_wbits(input logic [1:0] code);
        logic [5:0] n;
        case (code)
            2'b00:   n = 6'd8;
            2'b01:   n = 6'd16;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int             W   = 3,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta;
            logic stable;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta   <= RST[g];
                    stable <= RST[g];
                end else begin
                    meta   <= d[g];
                    stable <= meta;
                end
            end
            assign q[g] = stable;
        end
    endgenerate
endmodule

// File: rtl/spis_rxfifo.sv
module spis_rxfifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          ovf_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovf_evt = push && full && !do_pop;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the queue depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4: a rejected word leaves occupancy and the oldest entry unchanged
    p_keep_on_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count == $past(count)) && (head == $past(head)));
endmodule

// File: rtl/spis_engine.sv
module spis_engine
    import spis_pkg::*;
#(
    parameter int DW = SPIS_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          ss_stall,
    input  logic [1:0]    wsize,
    input  logic          sclk_s,
    input  logic          ss_s,
    input  logic          mosi_s,
    output spis_state_t   state,
    output logic          push,
    output logic [DW-1:0] push_data,
    output logic          load_evt,
    output logic          shift_evt,
    output logic [5:0]    wbits
);
    spis_state_t   state_nx;
    logic          sclk_d;
    logic [DW-2:0] rxsh;
    logic [5:0]    bitcnt;
    logic          edge_any, lead, trail, samp, drv, act, word_end;
    logic          edge_load, frame_load;
    logic [DW-1:0] mask;

    assign wbits = spis_wbits(wsize);
    assign mask  = {DW{1'b1}} >> (6'(DW) - wbits);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // Transitions: T_ENABLE, T_SELECT, T_DESELECT, T_DISABLE
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = S_OFF;                        // T_DISABLE
        end else begin
            unique case (state)
                S_OFF:    state_nx = S_IDLE;         // T_ENABLE
                S_IDLE:   if (!ss_s) state_nx = S_ACTIVE;   // T_SELECT
                S_ACTIVE: if (ss_s)  state_nx = S_IDLE;     // T_DESELECT
                default:  state_nx = S_OFF;
            endcase
        end
    end

    // Edge classification in the system clock domain
    assign edge_any = sclk_s ^ sclk_d;
    assign lead     = edge_any && (sclk_s ^ cpol);
    assign trail    = edge_any && !(sclk_s ^ cpol);
    assign samp     = cpha ? trail : lead;
    assign drv      = cpha ? lead  : trail;
    assign act      = (state == S_ACTIVE) && en && !ss_s;
    assign word_end = samp && (bitcnt == wbits - 6'd1);

    // Output decode
    always_comb begin
        push       = act && word_end;
        push_data  = {rxsh, mosi_s} & mask;
        edge_load  = act && drv && (bitcnt == 6'd0) && (cpha || ss_stall);
        frame_load = !cpha && en &&
                     ((state == S_OFF) || ((state == S_ACTIVE) && ss_s));
        load_evt   = edge_load || frame_load;
        shift_evt  = act && drv && !edge_load;
    end

    // Receive shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            rxsh   <= '0;
            bitcnt <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (act) begin
                if (samp) begin
                    rxsh   <= {rxsh[DW-3:0], mosi_s};
                    bitcnt <= word_end ? 6'd0 : bitcnt + 6'd1;
                end
            end else begin
                bitcnt <= '0;
            end
        end
    end

    // R8: nothing is captured or shifted while disabled
    p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |-> (!push && !shift_evt));

    // R1: the bit counter stays inside the selected word length
    p_bitcnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (bitcnt < wbits));
endmodule

// File: rtl/spis_txpath.sv
module spis_txpath #(
    parameter int DW    = 32,
    parameter int GUARD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          load_evt,
    input  logic          shift_evt,
    input  logic [5:0]    wbits,
    output logic          miso_bit,
    output logic          tx_full,
    output logic          collide
);
    localparam int GW = $clog2(GUARD + 1);

    logic [DW-1:0] hold, shreg;
    logic [GW-1:0] guard_cnt;

    assign collide  = tx_wr && (load_evt || (guard_cnt != '0));
    assign miso_bit = shreg[5'(wbits - 6'd1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            tx_full   <= 1'b0;
            shreg     <= '0;
            guard_cnt <= '0;
        end else begin
            if (load_evt) begin
                shreg     <= tx_full ? hold : '0;
                guard_cnt <= GW'(GUARD);
            end else begin
                if (shift_evt) shreg <= {shreg[DW-2:0], 1'b0};
                if (guard_cnt != '0) guard_cnt <= guard_cnt - 1'b1;
            end
            if (tx_wr) begin
                hold    <= tx_wdata;
                tx_full <= 1'b1;
            end else if (load_evt) begin
                tx_full <= 1'b0;
            end
        end
    end

    // R6: late data is kept for the next word
    p_keep_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (tx_full && (hold == $past(tx_wdata))));

    // R5: a load without a same-cycle write empties the holding register
    p_load_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && !tx_wr) |=> !tx_full);
endmodule

// File: rtl/spi_slave_err.sv
module spi_slave_err
    import spis_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int GUARD    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_ss_stall,
    input  logic [1:0]  cfg_wsize,
    input  logic        sclk,
    input  logic        ss_n,
    input  logic        mosi,
    output logic        miso,
    input  logic        tx_wr,
    input  logic [31:0] tx_wdata,
    output logic        tx_full,
    input  logic        rx_rd,
    output logic [31:0] rx_rdata,
    output logic        rx_empty,
    input  logic [1:0]  err_clr,
    output logic        err_ovf,
    output logic        err_txc
);
    localparam int DW = SPIS_DW;

    logic [2:0]    pins_s;
    spis_state_t   state;
    logic          push, load_evt, shift_evt, ovf_evt, collide, miso_bit;
    logic [DW-1:0] push_data;
    logic [5:0]    wbits;

    spis_sync #(.W(3), .RST(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({mosi, ss_n, sclk}), .q(pins_s)
    );

    spis_engine #(.DW(DW)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(cfg_en),
        .cpol(cfg_cpol), .cpha(cfg_cpha), .ss_stall(cfg_ss_stall),
        .wsize(cfg_wsize),
        .sclk_s(pins_s[0]), .ss_s(pins_s[1]), .mosi_s(pins_s[2]),
        .state(state), .push(push), .push_data(push_data),
        .load_evt(load_evt), .shift_evt(shift_evt), .wbits(wbits)
    );

    spis_rxfifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data), .pop(rx_rd),
        .head(rx_rdata), .empty(rx_empty), .ovf_evt(ovf_evt)
    );

    spis_txpath #(.DW(DW), .GUARD(GUARD)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .load_evt(load_evt), .shift_evt(shift_evt), .wbits(wbits),
        .miso_bit(miso_bit), .tx_full(tx_full), .collide(collide)
    );

    assign miso = (state == S_ACTIVE) && !pins_s[1] && miso_bit;

    // Sticky flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_ovf <= 1'b0;
            err_txc <= 1'b0;
        end else begin
            if (ovf_evt)         err_ovf <= 1'b1;
            else if (err_clr[0]) err_ovf <= 1'b0;
            if (collide)         err_txc <= 1'b1;
            else if (err_clr[1]) err_txc <= 1'b0;
        end
    end

    // R7: flags hold until cleared
    p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !err_clr[0]) |=> err_ovf);
    p_sticky_txc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_txc && !err_clr[1]) |=> err_txc);

    // R9: output line is quiet one cycle after disable
    p_miso_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !miso);
endmodule

// File: tb/tb_spi_slave_err.sv
module tb_spi_slave_err;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int NVEC       = 7;

    // {cpol, cpha, wsize[1:0], mosi word, miso word}
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'b00, 32'h0000_005A, 32'h0000_00C3},
        {1'b1, 1'b0, 2'b00, 32'h0000_0081, 32'h0000_007E},
        {1'b0, 1'b1, 2'b01, 32'h0000_1234, 32'h0000_BEEF},
        {1'b1, 1'b1, 2'b01, 32'h0000_F00D, 32'h0000_0F0F},
        {1'b0, 1'b0, 2'b10, 32'hDEAD_BEEF, 32'h1357_9BDF},
        {1'b1, 1'b1, 2'b11, 32'h8000_0001, 32'h7FFF_FFFE},
        {1'b0, 1'b1, 2'b00, 32'h0000_003C, 32'hAB00_00E1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_ss_stall = 1'b0;
    logic [1:0]  cfg_wsize = 2'b00;
    logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        tx_full;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_rdata;
    logic        rx_empty;
    logic [1:0]  err_clr = 2'b00;
    logic        err_ovf, err_txc;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_slave_err dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_ss_stall(cfg_ss_stall), .cfg_wsize(cfg_wsize),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .err_clr(err_clr), .err_ovf(err_ovf), .err_txc(err_txc)
    );

    function automatic logic [31:0] msk(input int nb);
        return (nb >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    endfunction

    function automatic int nbits(input logic [1:0] c);
        return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 32;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic stall, input logic [1:0] ws);
        @(negedge clk) cfg_en = 1'b0;
        wait_n(3);
        cfg_cpol = pol; cfg_cpha = pha; cfg_ss_stall = stall; cfg_wsize = ws;
        sclk = pol; ss_n = 1'b1;
        wait_n(4);
    endtask

    task automatic enable();
        @(negedge clk) cfg_en = 1'b1;
        wait_n(8);
    endtask

    task automatic write_tx(input logic [31:0] d);
        @(negedge clk) begin tx_wr = 1'b1; tx_wdata = d; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    // Master model. All pin changes happen at falling system clock edges.
    task automatic xfer(input int nb, input logic [31:0] mo, input logic keep,
                        input logic [1:0] clr_mask, input logic poke,
                        input logic [31:0] poke_data, output logic [31:0] mi);
        mi = '0;
        if (ss_n) begin
            @(negedge clk) ss_n = 1'b0;
            wait_n(H);
        end
        for (int i = nb - 1; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mosi = mo[i];
                wait_n(H);
                mi = {mi[30:0], miso};
                sclk = ~cfg_cpol;
                if (i == 0 && clr_mask != 2'b00) begin
                    @(posedge clk); @(posedge clk);
                    @(negedge clk) err_clr = clr_mask;
                    @(posedge clk);
                    @(negedge clk) err_clr = 2'b00;
                    wait_n(H - 3);
                end else begin
                    wait_n(H);
                end
                sclk = cfg_cpol;
            end else begin
                sclk = ~cfg_cpol;
                if (i == nb - 1 && poke) begin
                    @(posedge clk); @(posedge clk); @(posedge clk);
                    @(negedge clk) begin tx_wr = 1'b1; tx_wdata = poke_data; end
                    @(negedge clk) tx_wr = 1'b0;
                    wait_n(H - 4);
                end else begin
                    wait_n(H);
                end
                mosi = mo[i];
                mi = {mi[30:0], miso};
                sclk = cfg_cpol;
                if (i == 0 && clr_mask != 2'b00) begin
                    @(posedge clk); @(posedge clk);
                    @(negedge clk) err_clr = clr_mask;
                    @(posedge clk);
                    @(negedge clk) err_clr = 2'b00;
                    wait_n(H - 3);
                end else begin
                    wait_n(H);
                end
            end
        end
        wait_n(H);
        if (!keep) begin
            ss_n = 1'b1;
            wait_n(H);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R3/R9: reset state
        chk("R3 reset rx_empty", {31'd0, rx_empty}, 32'd1);
        chk("R3 reset tx_full", {31'd0, tx_full}, 32'd0);
        chk("R3 reset err_ovf", {31'd0, err_ovf}, 32'd0);
        chk("R3 reset err_txc", {31'd0, err_txc}, 32'd0);
        chk("R9 reset miso", {31'd0, miso}, 32'd0);

        // R1/R2: table of modes and sizes
        for (int v = 0; v < NVEC; v++) begin
            logic [67:0] e;
            int          nb;
            e  = VEC[v];
            nb = nbits(e[65:64]);
            set_cfg(e[67], e[66], 1'b0, e[65:64]);
            write_tx(e[31:0]);
            chk("R5 tx_full after write", {31'd0, tx_full}, 32'd1);
            enable();
            xfer(nb, e[63:32], 1'b0, 2'b00, 1'b0, '0, got);
            chk("R2 miso word", got, e[31:0] & msk(nb));
            chk("R1 rx word", rx_rdata, e[63:32] & msk(nb));
            chk("R3 rx not empty", {31'd0, rx_empty}, 32'd0);
            pop();
            chk("R3 rx empty after pop", {31'd0, rx_empty}, 32'd1);
            chk("R5 tx_full after load", {31'd0, tx_full}, 32'd0);
            chk("R6 no collision on early write", {31'd0, err_txc}, 32'd0);
        end

        // R8: ignored while disabled with select held low
        set_cfg(1'b0, 1'b0, 1'b0, 2'b00);
        @(negedge clk) ss_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            wait_n(H); sclk = 1'b1;
            wait_n(H); sclk = 1'b0;
        end
        wait_n(H);
        chk("R8 disabled no capture", {31'd0, rx_empty}, 32'd1);
        chk("R9 disabled miso quiet", {31'd0, miso}, 32'd0);
        @(negedge clk) ss_n = 1'b1;
        wait_n(H);

        // R8: partial word dropped on deselect
        enable();
        @(negedge clk) ss_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            wait_n(H); sclk = 1'b1;
            wait_n(H); sclk = 1'b0;
        end
        wait_n(H);
        ss_n = 1'b1;
        wait_n(H);
        chk("R8 partial word not stored", {31'd0, rx_empty}, 32'd1);
        xfer(8, 32'h0000_0042, 1'b0, 2'b00, 1'b0, '0, got);
        chk("R8 word after partial", rx_rdata, 32'h0000_0042);
        pop();

        // R4/R7: overflow, with the clear pulse landing in the same cycle
        set_cfg(1'b0, 1'b1, 1'b0, 2'b00);
        enable();
        for (int w = 0; w < 4; w++)
            xfer(8, 32'h10 + w, 1'b1, 2'b00, 1'b0, '0, got);
        chk("R4 no overflow when just full", {31'd0, err_ovf}, 32'd0);
        xfer(8, 32'h0000_00EE, 1'b0, 2'b01, 1'b0, '0, got);
        chk("R7 set wins over clear", {31'd0, err_ovf}, 32'd1);
        for (int w = 0; w < 4; w++) begin
            chk("R4 contents preserved", rx_rdata, 32'h10 + w);
            pop();
        end
        chk("R4 fifth word discarded", {31'd0, rx_empty}, 32'd1);
        chk("R7 flag still sticky", {31'd0, err_ovf}, 32'd1);
        @(negedge clk) err_clr = 2'b01;
        @(negedge clk) err_clr = 2'b00;
        chk("R7 overflow cleared", {31'd0, err_ovf}, 32'd0);

        // R5: phase 0 with stall, back-to-back words under one select
        set_cfg(1'b0, 1'b0, 1'b1, 2'b00);
        write_tx(32'h0000_0096);
        enable();
        write_tx(32'h0000_0069);
        wait_n(4);
        xfer(8, 32'h0000_0011, 1'b1, 2'b00, 1'b0, '0, got);
        chk("R5 stall word 1", got, 32'h0000_0096);
        xfer(8, 32'h0000_0022, 1'b0, 2'b00, 1'b0, '0, got);
        chk("R5 stall word 2 reloaded at final edge", got, 32'h0000_0069);
        chk("R5 stall no collision", {31'd0, err_txc}, 32'd0);
        chk("R1 stall rx 1", rx_rdata, 32'h0000_0011);
        pop();
        chk("R1 stall rx 2", rx_rdata, 32'h0000_0022);
        pop();

        // R6: phase 1, write just after the first leading edge
        set_cfg(1'b0, 1'b1, 1'b0, 2'b00);
        write_tx(32'h0000_00A5);
        enable();
        xfer(8, 32'h0, 1'b1, 2'b00, 1'b1, 32'h0000_003C, got);
        chk("R6 collided word uses old data", got, 32'h0000_00A5);
        chk("R6 collision flagged", {31'd0, err_txc}, 32'd1);
        chk("R6 late data kept", {31'd0, tx_full}, 32'd1);
        xfer(8, 32'h0, 1'b0, 2'b00, 1'b0, '0, got);
        chk("R6 late data sent next", got, 32'h0000_003C);
        pop(); pop();
        @(negedge clk) err_clr = 2'b10;
        @(negedge clk) err_clr = 2'b00;
        chk("R7 collision cleared", {31'd0, err_txc}, 32'd0);

        // R6: phase 0, write just after select deassertion
        set_cfg(1'b0, 1'b0, 1'b0, 2'b00);
        enable();
        xfer(8, 32'h0000_0055, 1'b1, 2'b00, 1'b0, '0, got);
        chk("R5 empty holding sends zero", got, 32'h0);
        @(negedge clk) ss_n = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk) begin tx_wr = 1'b1; tx_wdata = 32'h0000_00C9; end
        @(negedge clk) tx_wr = 1'b0;
        wait_n(H);
        chk("R6 deselect collision flagged", {31'd0, err_txc}, 32'd1);
        xfer(8, 32'h0, 1'b0, 2'b00, 1'b0, '0, got);
        chk("R6 word after late write is old", got, 32'h0);
        xfer(8, 32'h0, 1'b0, 2'b00, 1'b0, '0, got);
        chk("R6 late data sent one word later", got, 32'h0000_00C9);
        pop(); pop(); pop();
        chk("R3 drained", {31'd0, rx_empty}, 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule